// File: doc/BRIEF.md
# Buffered Block Serial Engine

This block moves a block of one or more bytes over a clocked serial link without help from the processor once launched. The bytes sit in a small buffer that software fills or empties over a simple byte-wide register bus. Software sets a first and a last buffer index, picks transmit or receive, chooses a serial clock (one of three divided-down internal rates, or a clock supplied from outside on the clock pin), and writes the launch bit. The engine lowers its select line, walks the buffer in ascending order, and shifts each byte least significant bit first. It drops the busy bit when the last byte is done and raises an interrupt request.

The sequencer has five named states. IDLE waits for a launch. LEAD holds select low with the clock idle for one serial period. SHIFT clocks out or in eight bits per byte. GAP holds the clock idle for two serial periods between bytes when gaps are enabled. TRAIL holds select low for one more period after the last bit. The transitions are: IDLE to LEAD on launch; LEAD to SHIFT when the lead period expires, or at once with the external clock; SHIFT to SHIFT when a byte ends and more bytes follow without a gap; SHIFT to GAP when a byte ends, more bytes follow and gaps are on; GAP to SHIFT when the gap expires; SHIFT to TRAIL when the last byte ends on an internal clock; SHIFT to IDLE when the last byte ends on the external clock; TRAIL to IDLE when the trail period expires.

With the external clock, a transfer ends after the planned number of rising clock edges. Any further rising edge that arrives before the next launch is flagged as an overrun.

Top module: `blkser_engine`

## Requirements
- R1: After reset the select line and the serial clock output are high, the data output is low, the interrupt request is low, and the control, pointer and status registers read 0x00.
- R2: Bus addresses 0x00 to 0x1F read and write buffer bytes 0 to 31. Address 0x20 is control: bit0 = 1 transmit / 0 receive, bit1 gap enable, bits 3:2 clock select, bit4 idle data level. Address 0x21 is the first index, 0x22 the last index, and 0x23 is status: bit7 busy, bit6 overrun, bit5 done.
- R3: Writing status with bit7 = 1 while idle launches a transfer. Busy reads 1 from the next cycle until the transfer ends and then clears by itself.
- R4: On an internal clock, select is low from the cycle after the launch write. It stays low for 2H cycles of lead, the whole byte stream, and 2H cycles of trail. H is the half period.
- R5: H is 2, 4 or 8 system cycles for clock select 0, 1 or 2. The serial clock idles high. Each bit is H cycles low followed by H cycles high.
- R6: In transmit mode the data output carries each byte least significant bit first, each bit held for its whole bit time.
- R7: In receive mode the input is sampled in the cycle before each rising serial clock edge, least significant bit first, and each byte is stored at the current index after its eighth bit.
- R8: A transfer handles the bytes from the first index to the last index inclusive, in ascending order. Equal indices move exactly one byte.
- R9: With gaps enabled, 4H cycles of idle-high clock separate consecutive bytes. With gaps disabled, the bytes follow back to back.
- R10: Outside the bit times of a transmit, and all through a receive, the data output equals the idle level bit.
- R11: The done bit (and the interrupt request) is set in the cycle busy falls. A status write with bit5 = 0, including a launch write, clears it.
- R12: Clock select 3 takes the serial clock from the clock input: the output driver is disabled, each synchronised rising edge shifts one bit, and the transfer ends right after the last byte's eighth rising edge with no lead, gap or trail period.
- R13: After an external-clock transfer ends, a further rising edge on the clock input before the next launch sets overrun. A status write with bit6 = 0, or a launch, clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 6 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| sck_in | input | 1 | Serial clock input used with the external clock |
| sck_out | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| cs_n | output | 1 | Active-low select |
| irq | output | 1 | Transfer-done interrupt request |

## Verification
The step that ends a byte can coincide with the step that ends the transfer. In receive mode, the final sample, the buffer store and (on the external clock) the return to IDLE with done set all land on the same edge. The bench provokes this with one-byte spans and with spans that end at the top buffer index. It judges the result by reading the stored bytes back over the bus and by comparing select, clock and data output against a cycle-by-cycle reference on every clock. A second collision, an external clock edge arriving right after completion while the overrun logic arms, is provoked with one extra pulse and judged through the status register.

// File: rtl/blkser_pkg.sv
package blkser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP,
        ST_TRAIL
    } blk_state_e;

    // control byte layout: {3'b0, idle_lvl, clk_sel[1:0], gap_en, tx_mode}
    typedef struct packed {
        logic       idle_lvl;
        logic [1:0] clk_sel;
        logic       gap_en;
        logic       tx_mode;
    } blk_ctrl_t;

    localparam logic [1:0] CLK_EXT = 2'd3;

    localparam int STAT_BUSY_BIT = 7;
    localparam int STAT_OVR_BIT  = 6;
    localparam int STAT_DONE_BIT = 5;

endpackage

// File: rtl/blkser_buffer.sv
module blkser_buffer #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata
);

    logic [7:0] mem_q [DEPTH];

    // engine store wins over a bus write to the same byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (eng_we && eng_waddr == AW'(i))
                    mem_q[i] <= eng_wdata;
                else if (bus_we && bus_addr == AW'(i))
                    mem_q[i] <= bus_wdata;
            end
        end
    end

    assign bus_rdata = mem_q[bus_addr];
    assign eng_rdata = mem_q[eng_raddr];

endmodule

// File: rtl/blkser_edge_sync.sv
module blkser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] && !sh_q[STAGES];

endmodule

// File: rtl/blkser_seq.sv
module blkser_seq
    import blkser_pkg::*;
#(
    parameter int BASE_HALF = 2,
    parameter int DEPTH     = 32,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  blk_ctrl_t     ctrl,
    input  logic [AW-1:0] first_idx,
    input  logic [AW-1:0] last_idx,
    input  logic          ext_rise,
    input  logic          si,
    input  logic [7:0]    eng_rdata,
    output logic [AW-1:0] eng_raddr,
    output logic          eng_we,
    output logic [AW-1:0] eng_waddr,
    output logic [7:0]    eng_wdata,
    output logic          busy,
    output logic          finish,
    output logic          sck_out,
    output logic          cs_n,
    output logic          so
);

    localparam int CW = $clog2(BASE_HALF * 16) + 1;

    blk_state_e    state_q, state_nx;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [AW-1:0] ptr_q;
    logic [7:0]    tx_q, rx_q;

    logic          ext;
    logic [CW-1:0] half, period, limit;
    logic          expire, sample, bit_end, byte_end, last_byte;
    logic [7:0]    rx_next;

    assign ext       = (ctrl.clk_sel == CLK_EXT);
    assign half      = CW'(BASE_HALF) << ctrl.clk_sel;
    assign period    = half << 1;
    assign limit     = (state_q == ST_GAP) ? (period << 1) - CW'(1) : period - CW'(1);
    assign expire    = (cnt_q == limit);
    assign sample    = (state_q == ST_SHIFT) && (ext ? ext_rise : (cnt_q == half - CW'(1)));
    assign bit_end   = (state_q == ST_SHIFT) && (ext ? ext_rise : expire);
    assign byte_end  = bit_end && (bit_q == 3'd7);
    assign last_byte = (ptr_q == last_idx);
    assign rx_next   = {si, rx_q[7:1]};

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_nx = ST_LEAD;
            ST_LEAD:  if (ext || expire) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (byte_end) begin
                    if (last_byte)                state_nx = ext ? ST_IDLE : ST_TRAIL;
                    else if (ctrl.gap_en && !ext) state_nx = ST_GAP;
                    else                          state_nx = ST_SHIFT;
                end
            end
            ST_GAP:   if (expire) state_nx = ST_SHIFT;
            ST_TRAIL: if (expire) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            ptr_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (state_nx != state_q || (state_q == ST_SHIFT && expire))
                cnt_q <= '0;
            else if (state_q != ST_IDLE)
                cnt_q <= cnt_q + CW'(1);

            if (start && state_q == ST_IDLE) begin
                bit_q <= '0;
                ptr_q <= first_idx;
            end else if (bit_end) begin
                bit_q <= bit_q + 3'd1;
                if (byte_end && !last_byte) ptr_q <= ptr_q + AW'(1);
            end

            if (state_q == ST_LEAD && (ext || expire))
                tx_q <= eng_rdata;
            else if (byte_end)
                tx_q <= eng_rdata;
            else if (bit_end)
                tx_q <= {1'b0, tx_q[7:1]};

            if (sample) rx_q <= rx_next;
        end
    end

    // buffer access: look one index ahead while shifting
    assign eng_raddr = (state_q == ST_SHIFT) ? ptr_q + AW'(1) : ptr_q;
    assign eng_we    = sample && (bit_q == 3'd7) && !ctrl.tx_mode;
    assign eng_waddr = ptr_q;
    assign eng_wdata = rx_next;

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        finish  = (state_q != ST_IDLE) && (state_nx == ST_IDLE);
        cs_n    = (state_q == ST_IDLE);
        sck_out = !((state_q == ST_SHIFT) && !ext && (cnt_q < half));
        so      = (state_q == ST_SHIFT && ctrl.tx_mode) ? tx_q[0] : ctrl.idle_lvl;
    end

    // R8: the index only advances while it has not yet reached the last index
    p_ptr_in_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ptr_q != $past(ptr_q)) |-> ($past(ptr_q) != $past(last_idx)));

    // R4: a falling serial clock only occurs inside a select frame
    p_sck_inside_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_out) |-> !cs_n);

endmodule

// File: rtl/blkser_engine.sv
module blkser_engine
    import blkser_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int BASE_HALF   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = $clog2(DEPTH),
    parameter int BW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [BW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    input  logic          si,
    output logic          so,
    output logic          cs_n,
    output logic          irq
);

    localparam logic [BW-1:0] A_CTRL  = BW'(DEPTH);
    localparam logic [BW-1:0] A_FIRST = BW'(DEPTH + 1);
    localparam logic [BW-1:0] A_LAST  = BW'(DEPTH + 2);
    localparam logic [BW-1:0] A_STAT  = BW'(DEPTH + 3);

    blk_ctrl_t     ctrl_q;
    logic [AW-1:0] first_q, last_q;
    logic          done_q, ovr_q, tail_q;

    logic          buf_sel, stat_wr, start_pulse;
    logic          busy, finish, ext_rise;
    logic [7:0]    buf_rdata, eng_rdata, eng_wdata;
    logic [AW-1:0] eng_raddr, eng_waddr;
    logic          eng_we;

    assign buf_sel     = !bus_addr[AW];
    assign stat_wr     = bus_wr && bus_addr == A_STAT;
    assign start_pulse = stat_wr && bus_wdata[STAT_BUSY_BIT] && !busy;

    blkser_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_wr && buf_sel),
        .bus_addr (bus_addr[AW-1:0]),
        .bus_wdata(bus_wdata),
        .bus_rdata(buf_rdata),
        .eng_we   (eng_we),
        .eng_waddr(eng_waddr),
        .eng_wdata(eng_wdata),
        .eng_raddr(eng_raddr),
        .eng_rdata(eng_rdata)
    );

    blkser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(sck_in),
        .rise    (ext_rise)
    );

    blkser_seq #(.BASE_HALF(BASE_HALF), .DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_pulse),
        .ctrl     (ctrl_q),
        .first_idx(first_q),
        .last_idx (last_q),
        .ext_rise (ext_rise),
        .si       (si),
        .eng_rdata(eng_rdata),
        .eng_raddr(eng_raddr),
        .eng_we   (eng_we),
        .eng_waddr(eng_waddr),
        .eng_wdata(eng_wdata),
        .busy     (busy),
        .finish   (finish),
        .sck_out  (sck_out),
        .cs_n     (cs_n),
        .so       (so)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL)  ctrl_q  <= bus_wdata[4:0];
            if (bus_addr == A_FIRST) first_q <= bus_wdata[AW-1:0];
            if (bus_addr == A_LAST)  last_q  <= bus_wdata[AW-1:0];
        end
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            tail_q <= 1'b0;
        end else begin
            if (finish)
                done_q <= 1'b1;
            else if (stat_wr && !bus_wdata[STAT_DONE_BIT])
                done_q <= 1'b0;

            if (ext_rise && tail_q && !busy)
                ovr_q <= 1'b1;
            else if (start_pulse || (stat_wr && !bus_wdata[STAT_OVR_BIT]))
                ovr_q <= 1'b0;

            if (finish && ctrl_q.clk_sel == CLK_EXT)
                tail_q <= 1'b1;
            else if (start_pulse)
                tail_q <= 1'b0;
        end
    end

    // bus read mux
    always_comb begin
        if (buf_sel) begin
            bus_rdata = buf_rdata;
        end else begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata = {3'b000, ctrl_q};
                A_FIRST: bus_rdata = 8'(first_q);
                A_LAST:  bus_rdata = 8'(last_q);
                A_STAT:  bus_rdata = {busy, ovr_q, done_q, 5'b00000};
                default: bus_rdata = 8'h00;
            endcase
        end
    end

    assign sck_oe = (ctrl_q.clk_sel != CLK_EXT);
    assign irq    = done_q;

    // R3: a launch write makes busy visible in the next cycle
    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> busy);

    // R11: done is already set in the cycle busy drops
    p_done_on_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R13: overrun only arises with the external clock selected
    p_overrun_ext_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(ctrl_q.clk_sel == CLK_EXT));

endmodule

// File: tb/blkser_engine_test.sv
module blkser_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, so, cs_n, irq;
    logic       si = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem_m [32];
    logic [7:0] rx_src [32];

    always #4 clk = ~clk;

    blkser_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so),
        .cs_n(cs_n), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // behavioural reference: list every expected cycle {cs_n, sck, so, si}
    task automatic run_xfer(input int sel, input bit tx, input bit gap,
                            input bit idl, input int sa, input int ea);
        logic [3:0] q[$];
        logic [3:0] e;
        int h;
        h = 2 << sel;
        bus_write(6'h20, {3'b000, idl, sel[1:0], gap, tx});
        bus_write(6'h21, 8'(sa));
        bus_write(6'h22, 8'(ea));
        chk(so == idl, "R10 idle level before launch", so, idl);
        for (int c = 0; c < 2 * h; c++) q.push_back({1'b0, 1'b1, idl, 1'b0});
        for (int b = sa; b <= ea; b++) begin
            for (int i = 0; i < 8; i++)
                for (int c = 0; c < 2 * h; c++)
                    q.push_back({1'b0, (c >= h), (tx ? mem_m[b][i] : idl),
                                 (tx ? 1'b0 : rx_src[b][i])});
            if (gap && b != ea)
                for (int c = 0; c < 4 * h; c++) q.push_back({1'b0, 1'b1, idl, 1'b0});
        end
        for (int c = 0; c < 2 * h; c++) q.push_back({1'b0, 1'b1, idl, 1'b0});
        bus_write(6'h23, 8'h80);
        bus_addr = 6'h23;
        while (q.size() > 0) begin
            e = q.pop_front();
            si = e[0];
            chk(cs_n == e[3], "R4 select frame", cs_n, e[3]);
            chk(sck_out == e[2], "R5 serial clock", sck_out, e[2]);
            chk(so == e[1], "R6/R10 data out", so, e[1]);
            chk(bus_rdata[7] == 1'b1, "R3 busy during transfer", bus_rdata[7], 1);
            @(negedge clk);
        end
        si = 1'b0;
        chk(cs_n == 1'b1, "R4 select released", cs_n, 1);
        chk(bus_rdata[7] == 1'b0, "R3 busy self-clears", bus_rdata[7], 0);
        chk(irq == 1'b1, "R11 done raised", irq, 1);
        chk(bus_rdata[5] == 1'b1, "R11 done bit", bus_rdata[5], 1);
        if (!tx) for (int b = sa; b <= ea; b++) mem_m[b] = rx_src[b];
    endtask

    task automatic ext_pulse(input logic d);
        @(negedge clk);
        sck_in = 1'b0; si = d;
        repeat (6) @(negedge clk);
        sck_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 32; i++) begin
            mem_m[i]  = 8'((i * 37 + 11) ^ 8'h5C);
            rx_src[i] = 8'((i * 13) ^ 8'hA5);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sck_out == 1'b1, "R1 sck reset", sck_out, 1);
        chk(so == 1'b0, "R1 so reset", so, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        rst_n = 1'b1;
        bus_read(6'h23, d); chk(d == 8'h00, "R1 status reset", d, 0);
        bus_read(6'h20, d); chk(d == 8'h00, "R1 control reset", d, 0);

        // R2: buffer map and register readback
        for (int i = 0; i < 32; i++) bus_write(6'(i), mem_m[i]);
        for (int i = 0; i < 32; i++) begin
            bus_read(6'(i), d);
            chk(d == mem_m[i], "R2 buffer readback", d, mem_m[i]);
        end
        bus_write(6'h21, 8'h07);
        bus_read(6'h21, d); chk(d == 8'h07, "R2 first index reg", d, 7);

        // R4 R5 R6 R8: transmit two bytes, fastest clock, no gap
        run_xfer(0, 1'b1, 1'b0, 1'b0, 0, 1);
        // R9 R10: gapped transmit, middle clock, idle level high
        run_xfer(1, 1'b1, 1'b1, 1'b1, 5, 7);
        // R11: done clears on a status write with bit5 = 0
        bus_write(6'h23, 8'h00);
        chk(irq == 1'b0, "R11 done cleared", irq, 0);
        // R7 R9: gapped receive at the top of the buffer
        run_xfer(0, 1'b0, 1'b1, 1'b0, 30, 31);
        for (int i = 29; i < 32; i++) begin
            bus_read(6'(i), d);
            chk(d == mem_m[i], "R7 received byte", d, mem_m[i]);
        end
        bus_read(6'h00, d); chk(d == mem_m[0], "R8 outside span untouched", d, mem_m[0]);
        // R8: single byte, slowest internal clock
        run_xfer(2, 1'b1, 1'b0, 1'b1, 12, 12);

        // R12: external clock receive of bytes 2..3
        bus_write(6'h20, 8'h0C);
        bus_write(6'h21, 8'h02);
        bus_write(6'h22, 8'h03);
        bus_write(6'h23, 8'h80);
        chk(sck_oe == 1'b0, "R12 clock driver off", sck_oe, 0);
        chk(cs_n == 1'b0, "R12 select low", cs_n, 0);
        for (int b = 2; b <= 3; b++)
            for (int i = 0; i < 8; i++) ext_pulse(rx_src[b][i]);
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1, "R12 frame ends", cs_n, 1);
        chk(irq == 1'b1, "R12 done after last edge", irq, 1);
        for (int b = 2; b <= 3; b++) begin
            bus_read(6'(b), d);
            chk(d == rx_src[b], "R12 external receive", d, rx_src[b]);
        end
        bus_read(6'h23, d); chk(d[6] == 1'b0, "R13 no overrun yet", d[6], 0);
        // R13: one stray clock edge
        ext_pulse(1'b0);
        bus_read(6'h23, d); chk(d[6] == 1'b1, "R13 overrun set", d[6], 1);
        bus_write(6'h23, 8'h00);
        bus_read(6'h23, d); chk(d == 8'h00, "R13 overrun cleared", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule